// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside a CPU core's instruction sequencer and decides when a pending maskable interrupt or an external halt request may be granted. The core reports each completed instruction with a strobe, together with an attribute saying whether that instruction may be followed by an interruption. Only at such interruptible boundaries does the block act. Stores, shifts and similar instructions are marked non-interruptible, so a request seen after them waits for a later boundary.

An external bus-request input halts the core at the first interruptible boundary and ignores the global interrupt enable. An interrupt also needs that enable to be set. Once an interrupt is accepted, the block clears the enable, drives a one-cycle acknowledge bus phase, pushes the return program counter at the stack pointer, and then redirects the core to a fixed vector. The stack pointer lives in this block. The core can load it, and each push increments it, so the stack grows toward higher addresses. While the block is busy it stalls the core.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset the enable flag is 0, the stack pointer equals SP_RESET (0x02F0), stall_o is 0, and intak_o, push_we_o, jump_o and busak_o are all 0.
- R2: A pending interrupt is not accepted while the enable flag is clear. The flag is updated by the instruction that completes at a boundary before the decision is made there. If ie_set_i and ie_clr_i are both set, the clear wins.
- R3: A pending interrupt is not accepted at the boundary of an instruction marked non-interruptible (insn_intr_ok_i = 0). It is accepted at the next boundary whose instruction is marked interruptible.
- R4: On acceptance at a boundary in cycle T, intak_o is high for exactly one cycle at T+1, the stack write follows at T+2, and the jump follows at T+3.
- R5: The stack write puts the pc_i value that was present at the accepting boundary at the address held in the stack pointer. The stack pointer then increments by 1.
- R6: The jump phase presents jump_addr_o = VECTOR (default 0x1004).
- R7: The enable flag reads 0 from the acknowledge cycle onward.
- R8: busak_o rises only after an interruptible boundary that saw busrq_i high, whatever the enable flag holds. It stays high while busrq_i stays high and falls one cycle after busrq_i drops.
- R9: When an interrupt and a bus request are pending at the same boundary, the halt is granted first. The acknowledge follows in the cycle after busak_o falls, provided the interrupt and the enable are still present.
- R10: intak_o, push_we_o, jump_o and busak_o are mutually exclusive, and stall_o is high whenever any of them is high.
- R11: A pulse on sp_wr_i while the block is idle loads sp_wdata_i into the stack pointer. The new value is seen on sp_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Maskable interrupt request, level |
| busrq_i | input | 1 | External halt request, level |
| insn_done_i | input | 1 | Instruction boundary strobe |
| insn_intr_ok_i | input | 1 | Completing instruction is interruptible |
| ie_set_i | input | 1 | Completing instruction sets the enable |
| ie_clr_i | input | 1 | Completing instruction clears the enable |
| pc_i | input | ADDR_W | Return address at the boundary |
| sp_wr_i | input | 1 | Stack pointer load strobe |
| sp_wdata_i | input | ADDR_W | Stack pointer load value |
| intak_o | output | 1 | Interrupt acknowledge bus phase |
| push_we_o | output | 1 | Stack write strobe |
| push_addr_o | output | ADDR_W | Stack write address |
| push_data_o | output | ADDR_W | Stack write data (return address) |
| jump_o | output | 1 | Redirect the core |
| jump_addr_o | output | ADDR_W | Redirect target |
| busak_o | output | 1 | Halt granted |
| stall_o | output | 1 | Core must hold |
| gie_o | output | 1 | Global interrupt enable |
| sp_o | output | ADDR_W | Stack pointer |

## Verification
The assertions assume that the core presents no instruction boundary and no stack pointer load while stall_o is high, because a halted or redirected core completes nothing. They also assume that ie_set_i, ie_clr_i and insn_intr_ok_i carry meaning only alongside insn_done_i. The stimulus task emits one-cycle boundary pulses and then waits for stall_o to drop before it issues the next boundary. It loads the stack pointer only in idle cycles, so the acknowledge, write, jump and halt phases are always judged against a well-formed instruction stream.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALT,
    ST_ACK,
    ST_PUSH,
    ST_JUMP
  } seq_state_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic gie_next_o,
  output logic gie_o
);
  logic gie_q;

  // clear beats set when one instruction carries both
  always_comb begin
    gie_next_o = gie_q;
    if (boundary_i) begin
      if (clr_i)      gie_next_o = 1'b0;
      else if (set_i) gie_next_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gie_q <= 1'b0;
    else if (take_i) gie_q <= 1'b0;
    else             gie_q <= gie_next_o;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_stack_unit.sv
module irq_stack_unit #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SP_RESET = 16'h02F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              push_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] ret_pc_o
);
  localparam logic [ADDR_W-1:0] SP_INIT = ADDR_W'(SP_RESET);
  localparam logic [ADDR_W-1:0] SP_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_q, pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_INIT;
    else if (push_i) sp_q <= sp_q + SP_STEP;
    else if (load_i) sp_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (capture_i) pc_q <= pc_i;
  end

  assign sp_o     = sp_q;
  assign ret_pc_o = pc_q;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic point_i,
  input  logic busrq_i,
  input  logic irq_i,
  input  logic gie_next_i,
  input  logic gie_i,
  output logic take_o,
  output logic idle_o,
  output logic halt_o,
  output logic ack_o,
  output logic push_o,
  output logic jump_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (point_i) begin
        if (busrq_i) state_d = ST_HALT;
        else if (irq_i && gie_next_i) begin
          state_d = ST_ACK;
          take_o  = 1'b1;
        end
      end
      ST_HALT: if (!busrq_i) begin
        if (irq_i && gie_i) begin
          state_d = ST_ACK;
          take_o  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_ACK:  state_d = ST_PUSH;
      ST_PUSH: state_d = ST_JUMP;
      ST_JUMP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign halt_o = (state_q == ST_HALT);
  assign ack_o  = (state_q == ST_ACK);
  assign push_o = (state_q == ST_PUSH);
  assign jump_o = (state_q == ST_JUMP);
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VECTOR   = 16'h1004,
  parameter logic [15:0] SP_RESET = 16'h02F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              busrq_i,
  input  logic              insn_done_i,
  input  logic              insn_intr_ok_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              sp_wr_i,
  input  logic [ADDR_W-1:0] sp_wdata_i,
  output logic              intak_o,
  output logic              push_we_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [ADDR_W-1:0] push_data_o,
  output logic              jump_o,
  output logic [ADDR_W-1:0] jump_addr_o,
  output logic              busak_o,
  output logic              stall_o,
  output logic              gie_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VECTOR);

  logic idle, halt, ack, push, jump, take, point, gie_next, gie_q;
  logic [ADDR_W-1:0] sp_q, ret_pc;

  // interruptible boundary seen while idle
  assign point = insn_done_i && insn_intr_ok_i && idle;

  irq_enable_reg u_enable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (insn_done_i && idle),
    .set_i      (ie_set_i),
    .clr_i      (ie_clr_i),
    .take_i     (take),
    .gie_next_o (gie_next),
    .gie_o      (gie_q)
  );

  irq_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .point_i    (point),
    .busrq_i    (busrq_i),
    .irq_i      (irq_i),
    .gie_next_i (gie_next),
    .gie_i      (gie_q),
    .take_o     (take),
    .idle_o     (idle),
    .halt_o     (halt),
    .ack_o      (ack),
    .push_o     (push),
    .jump_o     (jump)
  );

  irq_stack_unit #(
    .ADDR_W   (ADDR_W),
    .SP_RESET (SP_RESET)
  ) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (point),
    .pc_i       (pc_i),
    .push_i     (push),
    .load_i     (sp_wr_i && idle),
    .load_val_i (sp_wdata_i),
    .sp_o       (sp_q),
    .ret_pc_o   (ret_pc)
  );

  assign intak_o     = ack;
  assign push_we_o   = push;
  assign push_addr_o = sp_q;
  assign push_data_o = ret_pc;
  assign jump_o      = jump;
  assign jump_addr_o = VEC_ADDR;
  assign busak_o     = halt;
  assign stall_o     = !idle;
  assign gie_o       = gie_q;
  assign sp_o        = sp_q;
endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] VECTOR = 16'h1004
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              busrq_i,
  input logic              insn_done_i,
  input logic              insn_intr_ok_i,
  input logic              intak_o,
  input logic              push_we_o,
  input logic [ADDR_W-1:0] push_addr_o,
  input logic              jump_o,
  input logic [ADDR_W-1:0] jump_addr_o,
  input logic              busak_o,
  input logic              stall_o,
  input logic              gie_o,
  input logic [ADDR_W-1:0] sp_o
);
  // R4
  ack_then_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intak_o |=> push_we_o && !intak_o);
  // R6
  push_then_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_we_o |=> jump_o && jump_addr_o == ADDR_W'(VECTOR));
  // R5
  push_sp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_we_o |=> sp_o == $past(push_addr_o) + ADDR_W'(1));
  // R7
  ack_clears_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intak_o |-> !gie_o);
  // R3
  take_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intak_o && !$past(busak_o)) |-> $past(insn_done_i && insn_intr_ok_i && irq_i));
  // R8
  halt_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busak_o) |-> $past(insn_done_i && insn_intr_ok_i && busrq_i));
  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busak_o && busrq_i) |=> busak_o);
  // R9
  halt_to_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busak_o) && $past(irq_i && gie_o)) |-> intak_o);
  // R10
  single_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({intak_o, push_we_o, jump_o, busak_o}));
  // R10
  stall_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intak_o || push_we_o || jump_o || busak_o) |-> stall_o);
endmodule

bind irq_accept_seq irq_accept_seq_chk #(
  .ADDR_W (ADDR_W),
  .VECTOR (VECTOR)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .irq_i          (irq_i),
  .busrq_i        (busrq_i),
  .insn_done_i    (insn_done_i),
  .insn_intr_ok_i (insn_intr_ok_i),
  .intak_o        (intak_o),
  .push_we_o      (push_we_o),
  .push_addr_o    (push_addr_o),
  .jump_o         (jump_o),
  .jump_addr_o    (jump_addr_o),
  .busak_o        (busak_o),
  .stall_o        (stall_o),
  .gie_o          (gie_o),
  .sp_o           (sp_o)
);

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  localparam int EV_ACK  = 0;
  localparam int EV_PUSH = 1;
  localparam int EV_JUMP = 2;
  localparam int EV_HALT = 3;

  typedef struct {
    int          kind;
    logic [15:0] a;
    logic [15:0] d;
    string       req;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic irq = 0, busrq = 0, done = 0, iok = 0, iset = 0, iclr = 0, spwr = 0;
  logic [AW-1:0] pc = '0, spwd = '0;
  logic intak, pwe, jmp, busak, stall, gie;
  logic [AW-1:0] paddr, pdata, jaddr, sp;

  int n_chk = 0, n_fail = 0, n_ack = 0;
  logic busak_prev = 0;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_seq u_irq_accept_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .busrq_i(busrq),
    .insn_done_i(done), .insn_intr_ok_i(iok), .ie_set_i(iset), .ie_clr_i(iclr),
    .pc_i(pc), .sp_wr_i(spwr), .sp_wdata_i(spwd),
    .intak_o(intak), .push_we_o(pwe), .push_addr_o(paddr), .push_data_o(pdata),
    .jump_o(jmp), .jump_addr_o(jaddr), .busak_o(busak), .stall_o(stall),
    .gie_o(gie), .sp_o(sp)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [15:0] a, input logic [15:0] d, input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic score(input int kind, input logic [15:0] a, input logic [15:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, "R2/R3 unexpected event", kind, 32'hFFFF_FFFF);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind && e.a == a && e.d == d, e.req, {kind[3:0], a, d[11:0]}, {e.kind[3:0], e.a, e.d[11:0]});
    check(stall, "R10 stall during phase", stall, 1);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (intak) begin n_ack++; score(EV_ACK, 16'h0, 16'h0); end
      if (pwe)   score(EV_PUSH, paddr, pdata);
      if (jmp)   score(EV_JUMP, jaddr, 16'h0);
      if (busak && !busak_prev) score(EV_HALT, 16'h0, 16'h0);
      busak_prev = busak;
    end
  end

  task automatic boundary(input bit ok, input bit s, input bit c, input logic [AW-1:0] p);
    @(negedge clk);
    done = 1; iok = ok; iset = s; iclr = c; pc = p;
    @(negedge clk);
    done = 0; iok = 0; iset = 0; iclr = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    while (stall && !busrq) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(gie == 0, "R1 gie", gie, 0);
    check(sp == 16'h02F0, "R1 sp", sp, 16'h02F0);
    check(!stall && !intak && !pwe && !jmp && !busak, "R1 outputs", {stall, intak, pwe, jmp, busak}, 0);
    rst_n = 1;

    // R2 enable clear: pending irq ignored
    irq = 1;
    boundary(1, 0, 0, 16'h5000);
    settle(6);
    check(n_ack == 0, "R2 no accept gie=0", n_ack, 0);

    // R4 R5 R6: enable set by the completing instruction, accepted at once
    expect_ev(EV_ACK, 0, 0, "R4 ack");
    expect_ev(EV_PUSH, 16'h02F0, 16'h5010, "R5 push");
    expect_ev(EV_JUMP, 16'h1004, 0, "R6 jump");
    boundary(1, 1, 0, 16'h5010);
    settle(5);
    drained("R4 sequence complete");
    check(gie == 0, "R7 gie cleared", gie, 0);
    check(sp == 16'h02F1, "R5 sp incremented", sp, 16'h02F1);

    // R3 non-interruptible boundary defers
    boundary(0, 1, 0, 16'h5020);
    settle(5);
    check(n_ack == 1, "R3 not after non-interruptible", n_ack, 1);
    check(gie == 1, "R2 enable set", gie, 1);
    expect_ev(EV_ACK, 0, 0, "R3 ack");
    expect_ev(EV_PUSH, 16'h02F1, 16'h5030, "R5 push second");
    expect_ev(EV_JUMP, 16'h1004, 0, "R6 jump second");
    boundary(1, 0, 0, 16'h5030);
    settle(5);
    drained("R3 taken at next interruptible");
    check(sp == 16'h02F2, "R5 sp second", sp, 16'h02F2);

    // R2 set and clear together: clear wins
    boundary(1, 1, 1, 16'h5040);
    settle(5);
    check(n_ack == 2 && gie == 0, "R2 clear wins", {n_ack[7:0], gie}, {8'd2, 1'b0});

    // R11 stack pointer load
    @(negedge clk); spwr = 1; spwd = 16'h0400;
    @(negedge clk); spwr = 0;
    check(sp == 16'h0400, "R11 sp load", sp, 16'h0400);

    // R8 bus request: ignored at non-interruptible, granted despite gie=0
    irq = 0; busrq = 1;
    boundary(0, 0, 0, 16'h5050);
    repeat (3) @(negedge clk);
    check(!busak && !stall, "R8 no halt non-interruptible", busak, 0);
    expect_ev(EV_HALT, 0, 0, "R8 halt");
    boundary(1, 0, 0, 16'h5060);
    repeat (4) @(negedge clk);
    check(busak && stall, "R8 halt held", {busak, stall}, 2'b11);
    busrq = 0;
    @(negedge clk);
    check(!busak && !stall, "R8 halt released", {busak, stall}, 2'b00);
    drained("R8 events");

    // R9 both pending: halt first, then acceptance
    boundary(1, 1, 0, 16'h5070);
    settle(2);
    check(gie == 1 && n_ack == 2, "R9 enable armed", {gie, n_ack[7:0]}, {1'b1, 8'd2});
    irq = 1; busrq = 1;
    expect_ev(EV_HALT, 0, 0, "R9 halt first");
    expect_ev(EV_ACK, 0, 0, "R9 ack after halt");
    expect_ev(EV_PUSH, 16'h0400, 16'h5080, "R9 push");
    expect_ev(EV_JUMP, 16'h1004, 0, "R9 jump");
    boundary(1, 0, 0, 16'h5080);
    repeat (3) @(negedge clk);
    check(n_ack == 2 && busak, "R9 no ack during halt", n_ack, 2);
    busrq = 0;
    @(negedge clk);
    check(intak, "R9 ack right after release", intak, 1);
    irq = 0;
    settle(5);
    drained("R9 sequence complete");
    check(sp == 16'h0401, "R9 sp after push", sp, 16'h0401);

    finish_run();
  end
endmodule